// File: doc/BRIEF.md
# Write-Masked PHY Control Register Bank

This block is a small bank of 32-bit registers that configures an external storage-interface PHY. It sits behind a simple memory-mapped request port, with one request per cycle. Every write carries its own per-bit enables in the upper half-word of the write data. Software can therefore change one field without first reading the register back, and a write touches only the bits it names.

The bank has seven control registers and one read-only status word. The status word reflects two completion flags driven into the block by the PHY. The configuration fields are decoded from the stored bits and driven out as dedicated pins: power control, DLL enable, drive-strength code, DLL frequency code, output tap-delay enable and tap-delay value. Read data is registered and appears on the data output one cycle after the read request.

Top module: `phy_ctrl_regs`

## Requirements
- R1: On a write to a control register, stored bit x (x in 0..15) takes write-data bit x only when write-data bit x+16 is 1. Otherwise it keeps its previous value.
- R2: A read of a control register returns the stored 16 bits in bits 15:0 and zero in bits 31:16. The value is on the read-data output one clock after the request cycle.
- R3: Control registers sit at byte offsets 0x00, 0x04, ..., 0x18, seven in all, and each offset selects a distinct register.
- R4: A read of offset 0x20 returns calibration-done in bit 6 and DLL-ready in bit 5, each taken from its input pin, with every other bit zero.
- R5: Writes to offset 0x20, to offsets that are not word-aligned, or to any unmapped offset change no stored bit. Reads of unmapped or misaligned offsets return zero.
- R6: Reset clears every control bit. Power-on, DLL enable and all field outputs then read 0, so the PHY is powered down with the DLL off.
- R7: In the register at 0x18, bit 0 drives the power-on output (1 = powered), bit 1 drives the DLL-enable output, and bits 6:4 drive the drive-strength code (0=50, 1=33, 2=66, 3=100, 4=40 ohm).
- R8: In the register at 0x00, bits 13:12 drive the DLL frequency code (0=200, 1=50, 2=100, 3=150 MHz), bit 11 drives the tap-delay enable, and bits 10:7 drive the tap-delay value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the request |
| req_wdata | input | 32 | Write enables in 31:16, write values in 15:0 |
| rsp_rdata | output | 32 | Registered read data, valid the cycle after a read |
| cal_done_i | input | 1 | Calibration-complete flag from the PHY |
| dll_ready_i | input | 1 | DLL-locked flag from the PHY |
| pwr_on_o | output | 1 | PHY power-on (0 = powered down) |
| dll_en_o | output | 1 | DLL enable |
| drive_code_o | output | 3 | Output drive-strength code |
| dll_freq_o | output | 2 | DLL frequency code |
| tap_en_o | output | 1 | Output tap-delay enable |
| tap_sel_o | output | 4 | Output tap-delay value |

## Verification
The assertions assume that the two status flags are already synchronous to the clock. They also assume that every request field is at a known value in any cycle where req_valid is high. The bench drives all request inputs on the falling edge and holds them stable through the following rising edge. It changes the status pins only while no read is in flight, and it clears req_valid between operations so that each read's result can be sampled before the next request.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;
    localparam int WORD_W     = 32;
    localparam int HALF_W     = WORD_W / 2;
    localparam int ADDR_W     = 8;
    localparam int NUM_CTRL   = 7;
    localparam logic [ADDR_W-1:0] STATUS_OFF = 8'h20;

    // register indices whose fields feed the PHY pins
    localparam int PWR_REG    = 6;
    localparam int TIMING_REG = 0;

    // field positions inside the power register
    localparam int PWR_BIT    = 0;
    localparam int DLLEN_BIT  = 1;
    localparam int DRV_LSB    = 4;
    localparam int DRV_W      = 3;

    // field positions inside the timing register
    localparam int TAPSEL_LSB = 7;
    localparam int TAPSEL_W   = 4;
    localparam int TAPEN_BIT  = 11;
    localparam int FREQ_LSB   = 12;
    localparam int FREQ_W     = 2;

    // status bit positions
    localparam int CAL_BIT    = 6;
    localparam int LOCK_BIT   = 5;

    typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/phyreg_decode.sv
module phyreg_decode #(
    parameter int ADDR_W   = 8,
    parameter int NUM_CTRL = 7,
    parameter logic [ADDR_W-1:0] STATUS_OFF = 8'h20
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_CTRL-1:0] ctrl_sel,
    output logic                status_sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic aligned;
    logic [IDX_W-1:0] word_idx;

    assign aligned  = (addr[1:0] == 2'b00);
    assign word_idx = addr[ADDR_W-1:2];

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_sel
        assign ctrl_sel[i] = aligned && (word_idx == IDX_W'(i));
    end

    assign status_sel = (addr == STATUS_OFF);
endmodule

// File: rtl/phyreg_cell.sv
module phyreg_cell #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_val,
    input  logic [HALF_W-1:0] wr_mask,
    output logic [HALF_W-1:0] q
);
    typedef struct packed {
        logic [HALF_W-1:0] val;
    } cell_t;

    cell_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.val = (state_q.val & ~wr_mask) | (wr_val & wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign q = state_q.val;

    // bits without their enable never move on a write
    assert_masked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((q ^ $past(q)) & ~$past(wr_mask)) == '0));

    // enabled bits take the written value
    assert_masked_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & $past(wr_mask)) == ($past(wr_val) & $past(wr_mask))));

    // no write, no change
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
    import phyreg_pkg::*;
#(
    parameter int WORD_W_P   = WORD_W,
    parameter int ADDR_W_P   = ADDR_W,
    parameter int NUM_CTRL_P = NUM_CTRL
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W_P-1:0] req_addr,
    input  logic [WORD_W_P-1:0] req_wdata,
    output logic [WORD_W_P-1:0] rsp_rdata,
    input  logic                cal_done_i,
    input  logic                dll_ready_i,
    output logic                pwr_on_o,
    output logic                dll_en_o,
    output logic [DRV_W-1:0]    drive_code_o,
    output logic [FREQ_W-1:0]   dll_freq_o,
    output logic                tap_en_o,
    output logic [TAPSEL_W-1:0] tap_sel_o
);
    localparam int H_W = WORD_W_P / 2;

    typedef struct packed {
        logic [WORD_W_P-1:0] rdata;
    } top_t;

    logic [NUM_CTRL_P-1:0] ctrl_sel;
    logic                  status_sel;
    logic [H_W-1:0]        bank [NUM_CTRL_P];
    logic [NUM_CTRL_P*H_W-1:0] bank_flat;
    logic [WORD_W_P-1:0]   rd_val;
    top_t state_d, state_q;

    phyreg_decode #(
        .ADDR_W     (ADDR_W_P),
        .NUM_CTRL   (NUM_CTRL_P),
        .STATUS_OFF (STATUS_OFF[ADDR_W_P-1:0])
    ) u_decode (
        .addr       (req_addr),
        .ctrl_sel   (ctrl_sel),
        .status_sel (status_sel)
    );

    for (genvar i = 0; i < NUM_CTRL_P; i++) begin : g_reg
        phyreg_cell #(.HALF_W(H_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (req_valid && req_write && ctrl_sel[i]),
            .wr_val  (req_wdata[H_W-1:0]),
            .wr_mask (req_wdata[WORD_W_P-1:H_W]),
            .q       (bank[i])
        );
        assign bank_flat[i*H_W +: H_W] = bank[i];
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_CTRL_P; i++) begin
            if (ctrl_sel[i]) rd_val[H_W-1:0] = rd_val[H_W-1:0] | bank[i];
        end
        if (status_sel) begin
            rd_val[CAL_BIT]  = cal_done_i;
            rd_val[LOCK_BIT] = dll_ready_i;
        end
        state_d = state_q;
        if (req_valid && !req_write) state_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_rdata    = state_q.rdata;
    assign pwr_on_o     = bank[PWR_REG][PWR_BIT];
    assign dll_en_o     = bank[PWR_REG][DLLEN_BIT];
    assign drive_code_o = bank[PWR_REG][DRV_LSB +: DRV_W];
    assign dll_freq_o   = bank[TIMING_REG][FREQ_LSB +: FREQ_W];
    assign tap_en_o     = bank[TIMING_REG][TAPEN_BIT];
    assign tap_sel_o    = bank[TIMING_REG][TAPSEL_LSB +: TAPSEL_W];

    // at most one control register is selected by any offset
    assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_sel));

    // control reads never return upper-half bits
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (|ctrl_sel)) |=> (rsp_rdata[WORD_W_P-1:H_W] == '0));

    // status read reflects the flag pins of the request cycle
    assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && status_sel) |=>
        (rsp_rdata == ((WORD_W_P'($past(cal_done_i)) << CAL_BIT) |
                       (WORD_W_P'($past(dll_ready_i)) << LOCK_BIT))));

    // writes that hit no control register leave the whole bank alone
    assert_ignored_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !(|ctrl_sel)) |=> $stable(bank_flat));

    // unmapped reads return zero
    assert_unmapped_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !(|ctrl_sel) && !status_sel) |=> (rsp_rdata == '0));
endmodule

// File: tb/phy_ctrl_regs_test.sv
module phy_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        cal_done_i = 1'b0;
    logic        dll_ready_i = 1'b0;
    logic        pwr_on_o, dll_en_o, tap_en_o;
    logic [2:0]  drive_code_o;
    logic [1:0]  dll_freq_o;
    logic [3:0]  tap_sel_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    phy_ctrl_regs uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .cal_done_i (cal_done_i), .dll_ready_i (dll_ready_i),
        .pwr_on_o (pwr_on_o), .dll_en_o (dll_en_o),
        .drive_code_o (drive_code_o), .dll_freq_o (dll_freq_o),
        .tap_en_o (tap_en_o), .tap_sel_o (tap_sel_o)
    );

    // {req tag, write, addr, wdata, expected read data}
    localparam int NV = 22;
    localparam logic [76:0] VEC [NV] = '{
        {4'd7, 1'b1, 8'h18, 32'h0003_0003, 32'h0},          // R7 power on + DLL
        {4'd2, 1'b0, 8'h18, 32'h0,         32'h0000_0003},
        {4'd1, 1'b1, 8'h18, 32'h0070_0040, 32'h0},          // R1 drive code 4
        {4'd1, 1'b0, 8'h18, 32'h0,         32'h0000_0043},
        {4'd1, 1'b1, 8'h18, 32'h0001_0000, 32'h0},          // R1 clear bit 0 only
        {4'd1, 1'b0, 8'h18, 32'h0,         32'h0000_0042},
        {4'd8, 1'b1, 8'h00, 32'h3F80_3A00, 32'h0},          // R8 freq 3, tap on, tap 4
        {4'd8, 1'b0, 8'h00, 32'h0,         32'h0000_3A00},
        {4'd1, 1'b1, 8'h00, 32'h0000_FFFF, 32'h0},          // R1 no enables
        {4'd1, 1'b0, 8'h00, 32'h0,         32'h0000_3A00},
        {4'd3, 1'b1, 8'h04, 32'hFFFF_1234, 32'h0},          // R3 distinct register
        {4'd3, 1'b0, 8'h04, 32'h0,         32'h0000_1234},
        {4'd5, 1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0},          // R5 status write
        {4'd5, 1'b1, 8'h1C, 32'hFFFF_FFFF, 32'h0},          // R5 unmapped write
        {4'd5, 1'b0, 8'h1C, 32'h0,         32'h0},
        {4'd5, 1'b1, 8'h05, 32'hFFFF_5555, 32'h0},          // R5 misaligned write
        {4'd5, 1'b0, 8'h04, 32'h0,         32'h0000_1234},
        {4'd5, 1'b0, 8'h24, 32'h0,         32'h0},
        {4'd3, 1'b1, 8'h14, 32'hFFFF_ABCD, 32'h0},
        {4'd3, 1'b0, 8'h14, 32'h0,         32'h0000_ABCD},
        {4'd1, 1'b1, 8'h14, 32'h00F0_0000, 32'h0},          // R1 clear 7:4
        {4'd1, 1'b0, 8'h14, 32'h0,         32'h0000_AB0D}
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6 reset state
        check(6, {25'b0, pwr_on_o, dll_en_o, drive_code_o, dll_freq_o}, 32'h0);
        op(1'b0, 8'h18, 32'h0);
        check(6, rsp_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i][72], VEC[i][71:64], VEC[i][63:32]);
            if (!VEC[i][72]) check(int'(VEC[i][76:73]), rsp_rdata, VEC[i][31:0]);
        end

        // R7 field pins from register at 0x18 (value 0x0042)
        check(7, {31'b0, pwr_on_o}, 32'h0);
        check(7, {31'b0, dll_en_o}, 32'h1);
        check(7, {29'b0, drive_code_o}, 32'h4);
        // R8 field pins from register at 0x00 (value 0x3A00)
        check(8, {30'b0, dll_freq_o}, 32'h3);
        check(8, {31'b0, tap_en_o}, 32'h1);
        check(8, {28'b0, tap_sel_o}, 32'h4);

        // R4 status flag combinations
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cal_done_i = k[0]; dll_ready_i = k[1];
            op(1'b0, 8'h20, 32'h0);
            check(4, rsp_rdata, (32'(k[0]) << 6) | (32'(k[1]) << 5));
        end

        // R2 read data is registered: a write afterwards leaves it untouched
        op(1'b1, 8'h08, 32'hFFFF_0F0F);
        check(2, rsp_rdata, 32'h0000_0060);
        op(1'b0, 8'h08, 32'h0);
        check(2, rsp_rdata, 32'h0000_0F0F);

        // R6 reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(6, {25'b0, pwr_on_o, dll_en_o, drive_code_o, dll_freq_o}, 32'h0);
        check(6, {27'b0, tap_en_o, tap_sel_o}, 32'h0);
        op(1'b0, 8'h00, 32'h0);
        check(6, rsp_rdata, 32'h0);
        op(1'b0, 8'h08, 32'h0);
        check(6, rsp_rdata, 32'h0);

        finish_run();
    end
endmodule